// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when an 8-bit timer may advance. On any system clock cycle it gives the timer a one-cycle count-enable pulse, or no pulse. A 3-bit source field picks where the pulses come from. The options are no pulses at all, one pulse on every system clock, a pulse from one of four divided rates, or a pulse made from a chosen edge of an external clock pin. The pin is first brought into the system clock domain.

The divided rates all come from one 10-bit divider. The divider counts all the time and is meant to be shared with other timers. Changing the source field never restarts it, so the first divided pulse after a change can arrive at any point in the new period. A separate clear strobe restarts the divider from zero when software needs a known phase. The counter, the compare logic and the register access all sit outside this block.

Top module: `tick_source_sel`

## Requirements
- R1: With `clkSel` = 0, `tickOut` stays low on every cycle.
- R2: With `clkSel` = 1, `tickOut` is high on every cycle.
- R3: With `clkSel` = 2, 3, 4 or 5, `tickOut` is high for one cycle each time the divider's low 3, 6, 8 or 10 bits are all ones. The pulses are therefore exactly 8, 64, 256 or 1024 cycles apart. The divider reads 0 during reset and adds one on every clock edge after reset.
- R4: The divider advances on every cycle whatever `clkSel` holds. Changing `clkSel` keeps the divider's phase.
- R5: A high `prescaleClr` in one cycle makes the divider read 0 after the next clock edge. Counting then resumes from 0.
- R6: With `clkSel` = 7, a rising edge on `extPin` gives a one-cycle `tickOut`. With `clkSel` = 6, a falling edge does the same. When the pin changes just after an edge, the pulse appears in the cycle that starts two clock edges later.
- R7: External mode gives exactly one pulse per selected edge. The opposite edge and a steady pin give no pulse.
- R8: While `rstN` is low, the divider and the synchronizer flops are cleared, and `tickOut` is low for every `clkSel` except 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkSel | input | 3 | Source field: 0 off, 1 direct, 2 /8, 3 /64, 4 /256, 5 /1024, 6 pin falling, 7 pin rising |
| extPin | input | 1 | External clock pin, asynchronous |
| prescaleClr | input | 1 | Divider clear strobe |
| tickOut | output | 1 | One-cycle count-enable pulse for the timer |

## Verification
A wrong divider value shows at the port as divided pulses that land off their expected cycle. This is seen within one period of the selected rate: 8 cycles for the fastest tap, up to 1024 for the slowest. A missing clear shows on the first pulse after `prescaleClr`. A bad synchronizer or edge stage shows as a pulse that is missing, doubled or a cycle off, within three cycles of a pin edge. The bench therefore predicts every cycle's `tickOut` across source changes, divider clears and pin toggles. Any error in phase or in polarity then surfaces on the cycle it occurs.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

  // Codes of the source field
  typedef enum logic [2:0] {
    SRC_OFF      = 3'd0,
    SRC_DIRECT   = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } srcSel_e;

  localparam int NUM_TAPS = 4;

  // log2 of each divided ratio, tap 0 being the fastest
  function automatic int tapBits(input int idx);
    case (idx)
      0: return 3;
      1: return 6;
      2: return 8;
      default: return 10;
    endcase
  endfunction

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic                passAll;
    logic [NUM_TAPS-1:0] tapEn;
    logic                extEn;
    logic                extRise;
  } tickCtl_t;

endpackage

// File: rtl/tick_sel_ctrl.sv
module tick_sel_ctrl
  import tick_sel_pkg::*;
(
  input  logic [2:0] clkSel,
  output tickCtl_t   ctl
);

  srcSel_e selCode;

  always_comb begin
    selCode = srcSel_e'(clkSel);
    ctl     = '0;
    case (selCode)
      SRC_OFF:      ctl = '0;
      SRC_DIRECT:   ctl.passAll = 1'b1;
      SRC_DIV8:     ctl.tapEn[0] = 1'b1;
      SRC_DIV64:    ctl.tapEn[1] = 1'b1;
      SRC_DIV256:   ctl.tapEn[2] = 1'b1;
      SRC_DIV1024:  ctl.tapEn[3] = 1'b1;
      SRC_EXT_FALL: ctl.extEn = 1'b1;
      SRC_EXT_RISE: begin
        ctl.extEn   = 1'b1;
        ctl.extRise = 1'b1;
      end
      default:      ctl = '0;
    endcase
  end

  // At most one tap may be enabled at a time
  always_comb begin
    a_r3_single_tap: assert ($onehot0(ctl.tapEn));
  end

endmodule

// File: rtl/tick_sel_dp.sv
module tick_sel_dp
  import tick_sel_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  tickCtl_t ctl,
  input  logic     extPin,
  input  logic     prescaleClr,
  output logic     tick
);

  localparam int LAST_SYNC = SYNC_STAGES - 1;

  // Free-running shared divider
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            divCnt <= '0;
    else if (prescaleClr) divCnt <= '0;
    else                  divCnt <= divCnt + 1'b1;
  end

  // One pulse per tap when its low bits are all ones
  logic [NUM_TAPS-1:0] tapHit;

  generate
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam int TB = tapBits(t);
      if (TB <= DIV_W) begin : g_fit
        assign tapHit[t] = &divCnt[TB-1:0];
      end else begin : g_none
        assign tapHit[t] = 1'b0;
      end
    end
  endgenerate

  // Pin synchronizer and edge stage
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncLvl;
  logic                   riseEdge;
  logic                   fallEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      prevQ <= syncQ[LAST_SYNC];
    end
  end

  assign syncLvl  = syncQ[LAST_SYNC];
  assign riseEdge = syncLvl & ~prevQ;
  assign fallEdge = ~syncLvl & prevQ;

  logic extTick;
  assign extTick = ctl.extEn & (ctl.extRise ? riseEdge : fallEdge);
  assign tick    = ctl.passAll | (|(ctl.tapEn & tapHit)) | extTick;

  // R4: the divider moves on every cycle without a clear
  a_r4_free_run: assert property (@(posedge clk) disable iff (!rstN)
    !prescaleClr |=> divCnt == DIV_W'($past(divCnt) + 1'b1));

  // R5: a clear strobe zeroes the divider at the next edge
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    prescaleClr |=> divCnt == '0);

  // R7: an edge pulse never lasts two cycles
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge |=> !riseEdge);
  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> !fallEdge);

endmodule

// File: rtl/tick_source_sel.sv
module tick_source_sel
  import tick_sel_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] clkSel,
  input  logic       extPin,
  input  logic       prescaleClr,
  output logic       tickOut
);

  tickCtl_t ctl;

  tick_sel_ctrl u_ctrl (
    .clkSel (clkSel),
    .ctl    (ctl)
  );

  tick_sel_dp #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .extPin      (extPin),
    .prescaleClr (prescaleClr),
    .tick        (tickOut)
  );

  // R1: no source selected gives no pulses
  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0) |-> !tickOut);

  // R2: direct mode pulses on every cycle
  a_r2_direct_all: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd1) |-> tickOut);

endmodule

// File: tb/tick_source_sel_tb.sv
`timescale 1ns/1ps
module tick_source_sel_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = 3'd0;
  logic       extPin = 1'b0;
  logic       prescaleClr = 1'b0;
  logic       tickOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_source_sel u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .clkSel      (clkSel),
    .extPin      (extPin),
    .prescaleClr (prescaleClr),
    .tickOut     (tickOut)
  );

  // Scoreboard
  bit    expQ[$];
  string tagQ[$];

  // Driver-side model state
  int refCnt  = 0;
  bit lastClr = 0;
  bit lastPin = 0;
  bit p1 = 0, p2 = 0, p3 = 0;

  task automatic step(input logic [2:0] s, input bit pin, input bit clr, input string tag);
    bit e;
    @(posedge clk); #1;
    refCnt = lastClr ? 0 : (refCnt + 1) % 1024;
    p3 = p2; p2 = p1; p1 = lastPin;
    clkSel = s; extPin = pin; prescaleClr = clr;
    lastClr = clr; lastPin = pin;
    case (s)
      3'd0: e = 1'b0;
      3'd1: e = 1'b1;
      3'd2: e = (refCnt % 8) == 7;
      3'd3: e = (refCnt % 64) == 63;
      3'd4: e = (refCnt % 256) == 255;
      3'd5: e = refCnt == 1023;
      3'd6: e = !p2 && p3;
      default: e = p2 && !p3;
    endcase
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic run(input logic [2:0] s, input int n, input string tag);
    for (int i = 0; i < n; i++) step(s, lastPin, 1'b0, tag);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      bit    e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (tickOut !== e) begin
        errors++;
        $display("FAIL %s tickOut actual %b expected %b at %0t", t, tickOut, e, $time);
      end
    end
  end

  task automatic directCheck(input bit e, input string tag);
    checks++;
    if (tickOut !== e) begin
      errors++;
      $display("FAIL %s tickOut actual %b expected %b at %0t", tag, tickOut, e, $time);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    directCheck(1'b0, "R8");
    clkSel = 3'd2;
    @(negedge clk);
    directCheck(1'b0, "R8");
    clkSel = 3'd5;
    @(negedge clk);
    directCheck(1'b0, "R8");
    clkSel = 3'd0;
    rstN = 1'b1;

    run(3'd1, 12, "R2");
    run(3'd0, 20, "R1");
    run(3'd2, 40, "R3");
    run(3'd3, 150, "R3");
    // R4: switch rate mid-period without restarting the divider
    run(3'd0, 5, "R4");
    run(3'd2, 30, "R4");
    run(3'd1, 3, "R4");
    run(3'd3, 70, "R4");
    // R5: clear the divider, then check the new phase
    step(3'd2, 1'b0, 1'b1, "R5");
    run(3'd2, 20, "R5");
    step(3'd3, 1'b0, 1'b1, "R5");
    run(3'd3, 140, "R5");
    run(3'd4, 600, "R3");
    run(3'd5, 2100, "R3");
    // R6 and R7: external pin edges
    for (int k = 0; k < 6; k++) begin
      step(3'd7, 1'b1, 1'b0, "R6");
      run(3'd7, 4 + k, "R6");
      step(3'd7, 1'b0, 1'b0, "R7");
      run(3'd7, 5, "R7");
    end
    for (int k = 0; k < 6; k++) begin
      step(3'd6, 1'b1, 1'b0, "R7");
      run(3'd6, 5, "R7");
      step(3'd6, 1'b0, 1'b0, "R6");
      run(3'd6, 3 + k, "R6");
    end
    // R7: a steady pin gives no pulse
    run(3'd7, 10, "R7");
    run(3'd0, 4, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule